// File: doc/BRIEF.md
# Dual-Mode Serial Register Control Port

This block is a register-access slave for the control port of a converter. A host reaches a bank of 8-bit registers through one of two serial buses that share the same two pins. By default the port listens as a two-wire slave: SCL clocks bits, SDA carries them in both directions, and start and stop conditions frame each transfer. A single dual-use pin serves as the low address bit in two-wire mode and as the active-low chip select in three-wire mode. Once this pin has been seen high and then falls, the port moves into a write-only three-wire mode for good.

Every access goes through a pointer byte. Its top bit turns on auto-advance and its low four bits pick a register. When auto-advance is on, the pointer steps after each data byte, so a host can fill or dump a run of registers in a single transfer. When it is off, every byte lands on the same register. All pin inputs are brought into the system clock domain before any edge is detected. SDA is only ever pulled low, never driven high.

Top module: `ctlport_slave`

## Requirements
- R1: After reset every register reads 0x00, the pointer index is 0 with auto-advance off, and SDA is not pulled low.
- R2: In two-wire mode the slave answers only the 7-bit address 0b001000 followed by the current level of the dual-use pin, with R/W in bit 0 of the address byte. It acknowledges a match by holding SDA low through the ninth clock. On a mismatch it does not acknowledge and ignores every byte until the next start condition.
- R3: In a write, the first byte after the address is the pointer. Bit 7 is the auto-advance enable, bits 3:0 are the register index, and bits 6:4 have no effect. Each following byte is stored in the indexed register.
- R4: With auto-advance off, the index never changes on data bytes, so successive data bytes all overwrite one register. This holds on both buses.
- R5: With auto-advance on, the index increases by one after each data byte, whether written or read, and wraps from 15 to 0.
- R6: In a read (R/W = 1), the slave sends the indexed register MSB first after its address acknowledge, changing SDA only while SCL is low. It sends a further byte for each master acknowledge and stops sending after a master not-acknowledge.
- R7: The pointer can be reloaded only by the byte that follows a start condition and a write address. Its value persists across stop and repeated-start conditions, so a later read uses it.
- R8: The port switches to three-wire mode on the first falling edge of the dual-use pin after it has been sampled high. The switch is permanent, and after it two-wire transfers are neither acknowledged nor able to change any register.
- R9: In three-wire mode, while chip select is low, bits are taken MSB first on rising SCL from the SDA pin. The first byte of each select window is the pointer and later bytes are data, following R3 to R5. SDA is never pulled low in this mode.
- R10: SDA is pulled low only during acknowledge bits and read-data zero bits, it changes only while SCL is low, and it is released after a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock pin (two-wire clock or three-wire clock) |
| sda_i | input | 1 | Serial data pin level as seen on the wire |
| adcs_i | input | 1 | Dual-use pin: address bit in two-wire mode, active-low select in three-wire mode |
| sda_oe_o | output | 1 | When 1, the pad pulls SDA low |
| regs_o | output | NREG*8 | Register bank contents, register r in bits [8r+7:8r] |

## Verification
The bench goes after index wrap-around from 15 to 0 on writes and on reads. A design that stops at 15 or carries into a wider index writes the wrong register and returns the wrong byte. It sends a pointer byte with reserved bits set, which a careless decoder would turn into a bad index or a lost auto-advance flag. It checks that the pointer survives a stop and a repeated start, which an engine that clears state on every start would lose, and that a mismatched address is not acknowledged and its bytes are dropped. For the mode switch, it raises the dual-use pin without a switch, then lowers it. It then confirms that three-wire writes land with auto-advance on and off, that SDA is never pulled low, and that later two-wire traffic is locked out.

// File: rtl/ctlport_pkg.sv
package ctlport_pkg;
   localparam int BYTE_W = 8;
   localparam int ADDR_W = 7;

   typedef enum logic [2:0] {
      PS_IDLE,
      PS_RECV,
      PS_ACK,
      PS_SEND,
      PS_MACK
   } i2c_st_e;
endpackage

// File: rtl/ctlport_sync.sv
module ctlport_sync #(
   parameter int           N       = 1,
   parameter int           STAGES  = 2,
   parameter logic [N-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d_i,
   output logic [N-1:0] q_o,
   output logic [N-1:0] rise_o,
   output logic [N-1:0] fall_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("ctlport_sync needs at least two stages");
   end

   for (genvar b = 0; b < N; b++) begin : g_bit
      logic [STAGES-1:0] chain_q;
      logic              prev_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            chain_q <= {STAGES{RST_VAL[b]}};
            prev_q  <= RST_VAL[b];
         end else begin
            chain_q <= {chain_q[STAGES-2:0], d_i[b]};
            prev_q  <= chain_q[STAGES-1];
         end
      end

      assign q_o[b]    = chain_q[STAGES-1];
      assign rise_o[b] = chain_q[STAGES-1] & ~prev_q;
      assign fall_o[b] = ~chain_q[STAGES-1] & prev_q;
   end
endmodule

// File: rtl/ctlport_i2c_eng.sv
module ctlport_i2c_eng
   import ctlport_pkg::*;
#(
   parameter logic [ADDR_W-2:0] DEV_HI = 6'b001000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              scl_i,
   input  logic              scl_rise_i,
   input  logic              scl_fall_i,
   input  logic              sda_i,
   input  logic              sda_rise_i,
   input  logic              sda_fall_i,
   input  logic              ad0_i,
   input  logic [BYTE_W-1:0] rd_data_i,
   output logic [BYTE_W-1:0] wr_byte_o,
   output logic              map_we_o,
   output logic              dat_we_o,
   output logic              rd_adv_o,
   output logic              sda_oe_o
);
   localparam int CNT_W = $clog2(BYTE_W + 1);

   i2c_st_e           st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-1:0] sh_q;
   logic              rw_q;
   logic              addr_ph_q;
   logic              map_ph_q;
   logic              nack_q;
   logic              start_c;
   logic              stop_c;
   logic [ADDR_W-1:0] dev_addr;

   assign start_c  = sda_fall_i & scl_i;
   assign stop_c   = sda_rise_i & scl_i;
   assign dev_addr = {DEV_HI, ad0_i};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= PS_IDLE;
         cnt_q     <= '0;
         sh_q      <= '0;
         rw_q      <= 1'b0;
         addr_ph_q <= 1'b0;
         map_ph_q  <= 1'b0;
         nack_q    <= 1'b0;
         wr_byte_o <= '0;
         map_we_o  <= 1'b0;
         dat_we_o  <= 1'b0;
         rd_adv_o  <= 1'b0;
      end else begin
         map_we_o <= 1'b0;
         dat_we_o <= 1'b0;
         rd_adv_o <= 1'b0;
         if (!en_i) begin
            st_q <= PS_IDLE;
         end else if (start_c) begin
            st_q      <= PS_RECV;
            cnt_q     <= '0;
            addr_ph_q <= 1'b1;
         end else if (stop_c) begin
            st_q <= PS_IDLE;
         end else begin
            unique case (st_q)
               PS_RECV: begin
                  if (scl_rise_i) begin
                     sh_q  <= {sh_q[BYTE_W-2:0], sda_i};
                     cnt_q <= cnt_q + 1'b1;
                  end else if (scl_fall_i && cnt_q == CNT_W'(BYTE_W)) begin
                     cnt_q <= '0;
                     if (addr_ph_q) begin
                        addr_ph_q <= 1'b0;
                        if (sh_q[BYTE_W-1:1] == dev_addr) begin
                           rw_q     <= sh_q[0];
                           map_ph_q <= 1'b1;
                           st_q     <= PS_ACK;
                        end else begin
                           st_q <= PS_IDLE;
                        end
                     end else begin
                        wr_byte_o <= sh_q;
                        map_we_o  <= map_ph_q;
                        dat_we_o  <= ~map_ph_q;
                        map_ph_q  <= 1'b0;
                        st_q      <= PS_ACK;
                     end
                  end
               end
               PS_ACK: begin
                  if (scl_fall_i) begin
                     if (rw_q) begin
                        sh_q  <= rd_data_i;
                        cnt_q <= '0;
                        st_q  <= PS_SEND;
                     end else begin
                        st_q <= PS_RECV;
                     end
                  end
               end
               PS_SEND: begin
                  if (scl_fall_i) begin
                     if (cnt_q == CNT_W'(BYTE_W - 1)) begin
                        cnt_q    <= '0;
                        rd_adv_o <= 1'b1;
                        st_q     <= PS_MACK;
                     end else begin
                        sh_q  <= {sh_q[BYTE_W-2:0], 1'b0};
                        cnt_q <= cnt_q + 1'b1;
                     end
                  end
               end
               PS_MACK: begin
                  if (scl_rise_i) begin
                     nack_q <= sda_i;
                  end else if (scl_fall_i) begin
                     if (!nack_q) begin
                        sh_q <= rd_data_i;
                        st_q <= PS_SEND;
                     end else begin
                        st_q <= PS_IDLE;
                     end
                  end
               end
               default: st_q <= PS_IDLE;
            endcase
         end
      end
   end

   assign sda_oe_o = (st_q == PS_ACK) | ((st_q == PS_SEND) & ~sh_q[BYTE_W-1]);
endmodule

// File: rtl/ctlport_spi_rx.sv
module ctlport_spi_rx
   import ctlport_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_i,
   input  logic              cs_n_i,
   input  logic              sck_rise_i,
   input  logic              sdi_i,
   output logic [BYTE_W-1:0] wr_byte_o,
   output logic              map_we_o,
   output logic              dat_we_o
);
   localparam int CNT_W = $clog2(BYTE_W);

   logic [CNT_W-1:0]  cnt_q;
   logic [BYTE_W-2:0] sh_q;
   logic              first_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q     <= '0;
         sh_q      <= '0;
         first_q   <= 1'b1;
         wr_byte_o <= '0;
         map_we_o  <= 1'b0;
         dat_we_o  <= 1'b0;
      end else begin
         map_we_o <= 1'b0;
         dat_we_o <= 1'b0;
         if (!en_i || cs_n_i) begin
            cnt_q   <= '0;
            first_q <= 1'b1;
         end else if (sck_rise_i) begin
            if (cnt_q == CNT_W'(BYTE_W - 1)) begin
               wr_byte_o <= {sh_q, sdi_i};
               map_we_o  <= first_q;
               dat_we_o  <= ~first_q;
               first_q   <= 1'b0;
               cnt_q     <= '0;
            end else begin
               sh_q  <= {sh_q[BYTE_W-3:0], sdi_i};
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/ctlport_regbank.sv
module ctlport_regbank
   import ctlport_pkg::*;
#(
   parameter int NREG = 16,
   parameter int IDXW = 4
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   map_we_i,
   input  logic                   dat_we_i,
   input  logic                   adv_i,
   input  logic [BYTE_W-1:0]      wbyte_i,
   output logic [BYTE_W-1:0]      rd_data_o,
   output logic [NREG*BYTE_W-1:0] regs_o,
   output logic [IDXW-1:0]        idx_o,
   output logic                   incr_o
);
   if (NREG != (1 << IDXW)) begin : g_bad_depth
      $error("ctlport_regbank: NREG must equal 2**IDXW");
   end
   if (IDXW >= BYTE_W) begin : g_bad_idx
      $error("ctlport_regbank: index must leave room for the enable bit");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         incr_o <= 1'b0;
         idx_o  <= '0;
      end else if (map_we_i) begin
         incr_o <= wbyte_i[BYTE_W-1];
         idx_o  <= wbyte_i[IDXW-1:0];
      end else if ((dat_we_i || adv_i) && incr_o) begin
         idx_o <= idx_o + 1'b1;
      end
   end

   for (genvar r = 0; r < NREG; r++) begin : g_reg
      logic [BYTE_W-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cell_q <= '0;
         end else if (dat_we_i && idx_o == IDXW'(r)) begin
            cell_q <= wbyte_i;
         end
      end
      assign regs_o[r*BYTE_W +: BYTE_W] = cell_q;
   end

   assign rd_data_o = regs_o[idx_o*BYTE_W +: BYTE_W];
endmodule

// File: rtl/ctlport_slave.sv
module ctlport_slave
   import ctlport_pkg::*;
#(
   parameter int                NREG        = 16,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-2:0] DEV_HI      = 6'b001000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   input  logic                   adcs_i,
   output logic                   sda_oe_o,
   output logic [NREG*BYTE_W-1:0] regs_o
);
   localparam int IDXW = $clog2(NREG);

   logic [2:0]        pin_q;
   logic [2:0]        pin_rise;
   logic [2:0]        pin_fall;
   logic              scl_s;
   logic              sda_s;
   logic              adcs_s;
   logic              spi_mode_q;
   logic              unused_adcs_rise;

   logic [BYTE_W-1:0] i_byte;
   logic              i_map;
   logic              i_dat;
   logic              i_adv;
   logic              i_oe;
   logic [BYTE_W-1:0] s_byte;
   logic              s_map;
   logic              s_dat;

   logic [BYTE_W-1:0] ev_byte;
   logic              ev_map;
   logic              ev_dat;
   logic              ev_adv;
   logic [BYTE_W-1:0] rd_data;
   logic [IDXW-1:0]   map_idx;
   logic              map_incr;

   ctlport_sync #(
      .N       (3),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (3'b011)
   ) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .d_i    ({adcs_i, sda_i, scl_i}),
      .q_o    (pin_q),
      .rise_o (pin_rise),
      .fall_o (pin_fall)
   );

   assign scl_s            = pin_q[0];
   assign sda_s            = pin_q[1];
   assign adcs_s           = pin_q[2];
   assign unused_adcs_rise = pin_rise[2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         spi_mode_q <= 1'b0;
      end else if (pin_fall[2]) begin
         spi_mode_q <= 1'b1;
      end
   end

   ctlport_i2c_eng #(
      .DEV_HI (DEV_HI)
   ) u_i2c (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (~spi_mode_q),
      .scl_i      (scl_s),
      .scl_rise_i (pin_rise[0]),
      .scl_fall_i (pin_fall[0]),
      .sda_i      (sda_s),
      .sda_rise_i (pin_rise[1]),
      .sda_fall_i (pin_fall[1]),
      .ad0_i      (adcs_s),
      .rd_data_i  (rd_data),
      .wr_byte_o  (i_byte),
      .map_we_o   (i_map),
      .dat_we_o   (i_dat),
      .rd_adv_o   (i_adv),
      .sda_oe_o   (i_oe)
   );

   ctlport_spi_rx u_spi (
      .clk        (clk),
      .rst_n      (rst_n),
      .en_i       (spi_mode_q),
      .cs_n_i     (adcs_s),
      .sck_rise_i (pin_rise[0]),
      .sdi_i      (sda_s),
      .wr_byte_o  (s_byte),
      .map_we_o   (s_map),
      .dat_we_o   (s_dat)
   );

   assign ev_byte  = spi_mode_q ? s_byte : i_byte;
   assign ev_map   = spi_mode_q ? s_map  : i_map;
   assign ev_dat   = spi_mode_q ? s_dat  : i_dat;
   assign ev_adv   = ~spi_mode_q & i_adv;
   assign sda_oe_o = ~spi_mode_q & i_oe;

   ctlport_regbank #(
      .NREG (NREG),
      .IDXW (IDXW)
   ) u_bank (
      .clk       (clk),
      .rst_n     (rst_n),
      .map_we_i  (ev_map),
      .dat_we_i  (ev_dat),
      .adv_i     (ev_adv),
      .wbyte_i   (ev_byte),
      .rd_data_o (rd_data),
      .regs_o    (regs_o),
      .idx_o     (map_idx),
      .incr_o    (map_incr)
   );
endmodule

// File: rtl/ctlport_chk.sv
module ctlport_chk #(
   parameter int IDXW = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            scl_s,
   input logic            sda_oe,
   input logic            spi_mode,
   input logic [IDXW-1:0] map_idx,
   input logic            map_incr,
   input logic            ev_map,
   input logic            ev_dat,
   input logic            ev_adv
);
   // R8: once in three-wire mode the port stays there
   a_r8_mode_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      spi_mode |=> spi_mode);

   // R9: no pull-down while in three-wire mode
   a_r9_spi_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
      spi_mode |-> !sda_oe);

   // R10: the pull-down only moves while the synchronized clock is low
   a_r10_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_s);

   // R4: the index moves only in response to a pointer, data or read event
   a_r4_idx_needs_event: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(map_idx) |-> $past(ev_map || ev_dat || ev_adv));

   // R4: with auto-advance off, data and read events leave the index alone
   a_r4_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_map && !map_incr) |=> $stable(map_idx));

   // R5: with auto-advance on, each data or read event steps the index by one
   a_r5_idx_step: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_map && (ev_dat || ev_adv) && map_incr) |=>
         (map_idx == IDXW'($past(map_idx) + 1'b1)));
endmodule

bind ctlport_slave ctlport_chk #(.IDXW(IDXW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .scl_s    (scl_s),
   .sda_oe   (sda_oe_o),
   .spi_mode (spi_mode_q),
   .map_idx  (map_idx),
   .map_incr (map_incr),
   .ev_map   (ev_map),
   .ev_dat   (ev_dat),
   .ev_adv   (ev_adv)
);

// File: tb/ctlport_slave_bench.sv
module ctlport_slave_bench;
   localparam int CLK_P = 10;
   localparam int NREG  = 16;
   localparam int Q     = 8;
   localparam int WD    = 150000;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              scl;
   logic              msda;
   logic              adcs;
   logic              line;
   logic              sda_oe;
   logic [NREG*8-1:0] regs;

   int nchk = 0;
   int nerr = 0;
   int spi_oe_cnt = 0;
   bit spi_ph = 1'b0;
   bit done = 1'b0;

   logic [7:0] exp_q [$];
   string      tag_q [$];

   always #(CLK_P/2) clk = ~clk;

   assign line = msda & ~sda_oe;

   ctlport_slave #(.NREG(NREG)) u_ctlport_slave (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl),
      .sda_i    (line),
      .adcs_i   (adcs),
      .sda_oe_o (sda_oe),
      .regs_o   (regs)
   );

   always @(negedge clk) if (spi_ph && sda_oe) spi_oe_cnt++;

   task automatic hold(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] reg_at(input int i);
      return regs[i*8 +: 8];
   endfunction

   task automatic push_exp(input string tag, input logic [7:0] v);
      exp_q.push_back(v);
      tag_q.push_back(tag);
   endtask

   task automatic start_c();
      scl = 1'b0; hold(Q);
      msda = 1'b1; hold(Q);
      scl = 1'b1; hold(Q);
      msda = 1'b0; hold(Q);
      scl = 1'b0; hold(Q);
   endtask

   task automatic stop_c();
      msda = 1'b0; hold(Q);
      scl = 1'b1; hold(Q);
      msda = 1'b1; hold(2*Q);
   endtask

   task automatic wbit(input logic b);
      msda = b; hold(Q);
      scl = 1'b1; hold(Q);
      scl = 1'b0; hold(Q);
   endtask

   task automatic gbit(output logic b);
      msda = 1'b1; hold(Q);
      scl = 1'b1; hold(Q/2);
      b = line; hold(Q/2);
      scl = 1'b0; hold(Q);
   endtask

   task automatic wbyte(input logic [7:0] v, output logic ack);
      logic a;
      for (int i = 7; i >= 0; i--) wbit(v[i]);
      gbit(a);
      ack = ~a;
   endtask

   // monitor side of the scoreboard: each received byte is popped and compared
   task automatic rbyte(input bit last);
      logic [7:0] v;
      logic       b;
      string      t;
      logic [7:0] e;
      for (int i = 7; i >= 0; i--) begin
         gbit(b);
         v[i] = b;
      end
      wbit(last);
      if (exp_q.size() == 0) begin
         nchk++; nerr++;
         $display("FAIL R6 actual=%h expected=<none>", v);
      end else begin
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(t, v, e);
      end
   endtask

   task automatic spi_byte(input logic [7:0] v);
      for (int i = 7; i >= 0; i--) begin
         scl = 1'b0; msda = v[i]; hold(Q);
         scl = 1'b1; hold(Q);
      end
   endtask

   task automatic summary();
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
   endtask

   initial begin
      repeat (WD) @(posedge clk);
      if (!done) begin
         nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic ack;
      rst_n = 1'b0; scl = 1'b1; msda = 1'b1; adcs = 1'b0;
      hold(5);
      rst_n = 1'b1;
      hold(4);

      // R1: reset contents
      for (int i = 0; i < NREG; i++) chk("R1 reg reset", reg_at(i), 8'h00);
      chk("R1 sda released", {7'd0, sda_oe}, 8'h00);

      // R2 R3 R5: block write with auto-advance
      start_c();
      wbyte(8'h20, ack); chk("R2 address ack", {7'd0, ack}, 8'h01);
      wbyte(8'h83, ack); chk("R3 pointer ack", {7'd0, ack}, 8'h01);
      wbyte(8'hA1, ack); wbyte(8'hB2, ack); wbyte(8'hC3, ack);
      stop_c();
      chk("R3 first data", reg_at(3), 8'hA1);
      chk("R5 advance 1", reg_at(4), 8'hB2);
      chk("R5 advance 2", reg_at(5), 8'hC3);
      chk("R10 released after stop", {7'd0, sda_oe}, 8'h00);

      // R4: no advance
      start_c();
      wbyte(8'h20, ack); wbyte(8'h02, ack); wbyte(8'h11, ack); wbyte(8'h22, ack);
      stop_c();
      chk("R4 last byte wins", reg_at(2), 8'h22);
      chk("R4 neighbour untouched", reg_at(3), 8'hA1);

      // R2: wrong address ignored
      start_c();
      wbyte(8'h24, ack); chk("R2 no ack on mismatch", {7'd0, ack}, 8'h00);
      wbyte(8'h07, ack); wbyte(8'h55, ack);
      chk("R2 bytes ignored ack", {7'd0, ack}, 8'h00);
      stop_c();
      chk("R2 register untouched", reg_at(7), 8'h00);

      // R3 R5: reserved bits set, wrap from 15 to 0
      start_c();
      wbyte(8'h20, ack); wbyte(8'hFE, ack);
      wbyte(8'hE1, ack); wbyte(8'hF1, ack); wbyte(8'h01, ack);
      stop_c();
      chk("R3 reserved bits ignored", reg_at(14), 8'hE1);
      chk("R5 index 15", reg_at(15), 8'hF1);
      chk("R5 wrap to 0", reg_at(0), 8'h01);

      // R6 R7: read run, pointer kept across stop
      start_c(); wbyte(8'h20, ack); wbyte(8'h83, ack); stop_c();
      start_c();
      wbyte(8'h21, ack); chk("R6 read address ack", {7'd0, ack}, 8'h01);
      push_exp("R6 read 1", 8'hA1); push_exp("R6 read 2", 8'hB2); push_exp("R6 read 3", 8'hC3);
      rbyte(1'b0); rbyte(1'b0); rbyte(1'b1);
      stop_c();
      chk("R10 released after read", {7'd0, sda_oe}, 8'h00);

      // R6: no advance on reads
      start_c(); wbyte(8'h20, ack); wbyte(8'h04, ack); stop_c();
      start_c(); wbyte(8'h21, ack);
      push_exp("R6 repeat 1", 8'hB2); push_exp("R6 repeat 2", 8'hB2);
      rbyte(1'b0); rbyte(1'b1);
      stop_c();
      start_c(); wbyte(8'h21, ack);
      push_exp("R7 pointer persists", 8'hB2);
      rbyte(1'b1);
      stop_c();

      // R5 R7: repeated start, read wraps
      start_c(); wbyte(8'h20, ack); wbyte(8'h8E, ack);
      start_c(); wbyte(8'h21, ack);
      push_exp("R7 repeated start", 8'hE1); push_exp("R5 read 15", 8'hF1); push_exp("R5 read wrap", 8'h01);
      rbyte(1'b0); rbyte(1'b0); rbyte(1'b1);
      stop_c();

      // R2: address follows the dual-use pin
      adcs = 1'b1; hold(4*Q);
      start_c();
      wbyte(8'h20, ack); chk("R2 old address refused", {7'd0, ack}, 8'h00);
      wbyte(8'h00, ack); wbyte(8'h99, ack);
      stop_c();
      chk("R2 refused write dropped", reg_at(0), 8'h01);
      start_c();
      wbyte(8'h22, ack); chk("R2 new address ack", {7'd0, ack}, 8'h01);
      wbyte(8'h01, ack); wbyte(8'h5A, ack);
      stop_c();
      chk("R2 new address write", reg_at(1), 8'h5A);

      // R8 R9: falling select switches to three-wire mode
      spi_ph = 1'b1;
      adcs = 1'b0; hold(2*Q);
      spi_byte(8'h88); spi_byte(8'h10); spi_byte(8'h20);
      hold(Q); adcs = 1'b1; hold(2*Q);
      chk("R9 spi first data", reg_at(8), 8'h10);
      chk("R9 spi advance", reg_at(9), 8'h20);
      adcs = 1'b0; hold(2*Q);
      spi_byte(8'h0A); spi_byte(8'h33); spi_byte(8'h44);
      hold(Q); adcs = 1'b1; hold(2*Q);
      chk("R4 spi no advance", reg_at(10), 8'h44);
      chk("R4 spi neighbour", reg_at(11), 8'h00);

      // R8: two-wire locked out
      scl = 1'b1; msda = 1'b1; hold(2*Q);
      start_c();
      wbyte(8'h22, ack); chk("R8 no ack after switch", {7'd0, ack}, 8'h00);
      wbyte(8'h0B, ack); wbyte(8'h77, ack);
      stop_c();
      chk("R8 no write after switch", reg_at(11), 8'h00);
      chk("R9 never pulled low", spi_oe_cnt[7:0], 8'h00);
      chk("R6 scoreboard drained", 8'(exp_q.size()), 8'h00);

      done = 1'b1;
      summary();
      $finish;
   end
endmodule